// File: doc/BRIEF.md
# Delay-Line Ring Address Generator

This block turns the memory fields of one signal-processing microcode step into a word address for the external sample memory. In ring mode a selected 16-bit base register is offset by the per-sample ring position. An optional 12-bit address register and an optional increment are added. The sum is folded into a power-of-two ring, and the ring's placement in memory is then added. In table mode the ring position and the ring fold are skipped, so fixed tables can be read. Any address beyond the top of memory is replaced by zero.

The sequencer presents one step per valid cycle. The address and the read and write strobes are registered and appear one cycle after the step. Memory accesses are only granted on odd-numbered steps, and a request on an even step raises no strobe. The block also owns the 12-bit address register, which a step can load from the shifter output or from the upper byte of the step's input value.

Top module: `ring_addr_gen`

## Requirements
- R1: After reset, addr_o is 0, rd_o and wr_o are low, the ring length is 0x8000, the ring placement is 0, the address register is 0 and all 32 base registers are 0.
- R2: In ring mode (tbl_mode_i=0), a requesting step yields addr_o = ((base + ring_ofs_i + extras) mod 2^16 AND (ring_len - 1)) + ring_base*4096, one cycle after the step.
- R3: In table mode (tbl_mode_i=1), ring_ofs_i is not added and the sum is masked to 16 bits instead of to the ring length.
- R4: add_areg_i=1 adds the address register (zero-extended) and add_one_i=1 adds 1, both before the masking.
- R5: When the placed address exceeds 0x7FFFF, addr_o is 0.
- R6: rd_o (or wr_o) is high one cycle after a valid step with rd_req_i (or wr_req_i) only when step_idx_i bit 0 is 1. On an even step the address still updates but both strobes stay low.
- R7: A valid step with neither rd_req_i nor wr_req_i leaves both strobes low and addr_o unchanged.
- R8: On a valid step with areg_ld_i=1, the address register loads shift_val_i[23:12] when shift_mode_i=3. Otherwise it loads in_val_i[23:16] sign-extended to 12 bits. An address computed in the same step uses the value held before the load.
- R9: While step_vld_i is low, the step fields have no effect: both strobes are low, addr_o holds and the address register holds.
- R10: base_we_i writes base_data_i into the base register at base_idx_i. cfg_we_i writes the ring length and the ring placement. Both take effect for steps in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Base register write enable |
| base_idx_i | input | 5 | Base register write index |
| base_data_i | input | 16 | Base register write data |
| cfg_we_i | input | 1 | Ring configuration write enable |
| ring_len_i | input | 17 | Ring length, a power of two |
| ring_base_i | input | 7 | Ring placement in 4096-word units |
| step_vld_i | input | 1 | Step present this cycle |
| step_idx_i | input | 7 | Step number within the sample |
| ring_ofs_i | input | 16 | Per-sample ring position |
| tbl_mode_i | input | 1 | Table mode: no ring position, no ring fold |
| rd_req_i | input | 1 | Step requests a memory read |
| wr_req_i | input | 1 | Step requests a memory write |
| base_sel_i | input | 5 | Base register selected by the step |
| add_areg_i | input | 1 | Add the address register |
| add_one_i | input | 1 | Add one |
| areg_ld_i | input | 1 | Load the address register |
| shift_mode_i | input | 2 | Shifter mode of the step |
| shift_val_i | input | 24 | Shifter output of the step |
| in_val_i | input | 24 | Input operand of the step |
| addr_o | output | 19 | Registered memory word address |
| rd_o | output | 1 | Registered read strobe |
| wr_o | output | 1 | Registered write strobe |

## Verification
Directed steps first cover the default ring length and a sum that crosses the ring boundary, which shows whether the fold is a mask or is missing. Table steps with a large offset show whether the ring position leaks into table addresses. Steps that load and use the address register in the same cycle tell old-value from new-value ordering. Separate loads cover the positive and negative input byte and shift mode 3. Random steps follow with random power-of-two ring lengths, placements, parities and request mixes, and every cycle is compared against a behavioural model.

// File: rtl/ring_addr_gen_pkg.sv
package ring_addr_gen_pkg;
  localparam int unsigned N_BASE   = 32;
  localparam int unsigned SEL_W    = $clog2(N_BASE);
  localparam int unsigned BASE_W   = 16;
  localparam int unsigned AREG_W   = 12;
  localparam int unsigned RBASE_W  = 7;
  localparam int unsigned PLACE_SH = 12;
  localparam int unsigned MEM_AW   = 19;
  localparam int unsigned FULL_W   = MEM_AW + 1;
  localparam int unsigned RLEN_W   = BASE_W + 1;
  localparam int unsigned DATA_W   = 24;
  localparam int unsigned IN_SH    = 16;
  localparam int unsigned STEP_W   = 7;
  localparam logic [RLEN_W-1:0] RLEN_RST = RLEN_W'(17'h08000);
  localparam logic [FULL_W-1:0] MEM_TOP  = FULL_W'((1 << MEM_AW) - 1);

  typedef enum logic [1:0] {
    SH_SAT1 = 2'd0,
    SH_SAT2 = 2'd1,
    SH_WRP2 = 2'd2,
    SH_WRP1 = 2'd3
  } shift_mode_e;
endpackage

// File: rtl/ring_addr_gen_base_rf.sv
module ring_addr_gen_base_rf
  import ring_addr_gen_pkg::*;
#(
  parameter int unsigned N = N_BASE,
  parameter int unsigned W = BASE_W,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] regs_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && widx_i == IW'(g)) regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[ridx_i];
endmodule

// File: rtl/ring_addr_gen_areg.sv
module ring_addr_gen_areg
  import ring_addr_gen_pkg::*;
#(
  parameter int unsigned AW = AREG_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SH = IN_SH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] shift_val_i,
  input  logic [DW-1:0] in_val_i,
  output logic [AW-1:0] areg_o
);
  logic [DW-1:0] in_sra;
  logic [AW-1:0] nxt;
  logic          unused_bits;

  assign in_sra = DW'($signed(in_val_i) >>> SH);
  assign unused_bits = ^{shift_val_i[DW-AW-1:0], in_sra[DW-1:AW]};

  always_comb begin
    if (shift_mode_e'(mode_i) == SH_WRP1) nxt = shift_val_i[DW-1 -: AW];
    else                                  nxt = in_sra[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   areg_o <= '0;
    else if (ld_i) areg_o <= nxt;
  end
endmodule

// File: rtl/ring_addr_gen_calc.sv
module ring_addr_gen_calc
  import ring_addr_gen_pkg::*;
#(
  parameter int unsigned BW  = BASE_W,
  parameter int unsigned AW  = AREG_W,
  parameter int unsigned RW  = RBASE_W,
  parameter int unsigned MAW = MEM_AW,
  localparam int unsigned FW = MAW + 1,
  localparam int unsigned LW = BW + 1
) (
  input  logic [BW-1:0]  base_i,
  input  logic [BW-1:0]  ofs_i,
  input  logic [AW-1:0]  areg_i,
  input  logic           tbl_i,
  input  logic           add_areg_i,
  input  logic           add_one_i,
  input  logic [LW-1:0]  rlen_i,
  input  logic [RW-1:0]  rbase_i,
  output logic [MAW-1:0] addr_o
);
  logic [BW-1:0] sum, masked;
  logic [LW-1:0] len_m1;
  logic [FW-1:0] placed;
  logic          unused_len;

  assign len_m1     = rlen_i - LW'(1);
  assign unused_len = len_m1[LW-1];

  always_comb begin
    sum = base_i;
    if (!tbl_i)     sum = sum + ofs_i;
    if (add_areg_i) sum = sum + BW'(areg_i);
    if (add_one_i)  sum = sum + BW'(1);
    masked = tbl_i ? sum : (sum & len_m1[BW-1:0]);
    placed = FW'(masked) + (FW'(rbase_i) << PLACE_SH);
    addr_o = (placed > MEM_TOP) ? '0 : placed[MAW-1:0];
  end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
  import ring_addr_gen_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                base_we_i,
  input  logic [SEL_W-1:0]    base_idx_i,
  input  logic [BASE_W-1:0]   base_data_i,
  input  logic                cfg_we_i,
  input  logic [RLEN_W-1:0]   ring_len_i,
  input  logic [RBASE_W-1:0]  ring_base_i,
  input  logic                step_vld_i,
  input  logic [STEP_W-1:0]   step_idx_i,
  input  logic [BASE_W-1:0]   ring_ofs_i,
  input  logic                tbl_mode_i,
  input  logic                rd_req_i,
  input  logic                wr_req_i,
  input  logic [SEL_W-1:0]    base_sel_i,
  input  logic                add_areg_i,
  input  logic                add_one_i,
  input  logic                areg_ld_i,
  input  logic [1:0]          shift_mode_i,
  input  logic [DATA_W-1:0]   shift_val_i,
  input  logic [DATA_W-1:0]   in_val_i,
  output logic [MEM_AW-1:0]   addr_o,
  output logic                rd_o,
  output logic                wr_o
);
  logic [BASE_W-1:0]  base_rd;
  logic [AREG_W-1:0]  areg_q;
  logic [RLEN_W-1:0]  rlen_q;
  logic [RBASE_W-1:0] rbase_q;
  logic [MEM_AW-1:0]  addr_d;
  logic               acc_req, odd_step, unused_step;

  assign odd_step    = step_idx_i[0];
  assign unused_step = ^step_idx_i[STEP_W-1:1];
  assign acc_req     = step_vld_i && (rd_req_i || wr_req_i);

  ring_addr_gen_base_rf #(.N(N_BASE), .W(BASE_W)) u_base_rf (
    .clk_i, .rst_ni,
    .we_i    (base_we_i),
    .widx_i  (base_idx_i),
    .wdata_i (base_data_i),
    .ridx_i  (base_sel_i),
    .rdata_o (base_rd)
  );

  ring_addr_gen_areg #(.AW(AREG_W), .DW(DATA_W), .SH(IN_SH)) u_areg (
    .clk_i, .rst_ni,
    .ld_i        (step_vld_i && areg_ld_i),
    .mode_i      (shift_mode_i),
    .shift_val_i (shift_val_i),
    .in_val_i    (in_val_i),
    .areg_o      (areg_q)
  );

  ring_addr_gen_calc #(.BW(BASE_W), .AW(AREG_W), .RW(RBASE_W), .MAW(MEM_AW)) u_calc (
    .base_i     (base_rd),
    .ofs_i      (ring_ofs_i),
    .areg_i     (areg_q),
    .tbl_i      (tbl_mode_i),
    .add_areg_i (add_areg_i),
    .add_one_i  (add_one_i),
    .rlen_i     (rlen_q),
    .rbase_i    (rbase_q),
    .addr_o     (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rlen_q  <= RLEN_RST;
      rbase_q <= '0;
    end else if (cfg_we_i) begin
      rlen_q  <= ring_len_i;
      rbase_q <= ring_base_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
    end else begin
      rd_o <= step_vld_i && rd_req_i && odd_step;
      wr_o <= step_vld_i && wr_req_i && odd_step;
      if (acc_req) addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/ring_addr_gen_chk.sv
module ring_addr_gen_chk
  import ring_addr_gen_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_vld_i,
  input logic [STEP_W-1:0] step_idx_i,
  input logic              rd_req_i,
  input logic              wr_req_i,
  input logic              areg_ld_i,
  input logic [MEM_AW-1:0] addr_o,
  input logic              rd_o,
  input logic              wr_o,
  input logic [AREG_W-1:0] areg_q
);
  // R6
  rd_odd_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> $past(step_vld_i && rd_req_i && step_idx_i[0]));
  // R6
  wr_odd_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(step_vld_i && wr_req_i && step_idx_i[0]));
  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(step_vld_i && (rd_req_i || wr_req_i)) |-> $stable(addr_o));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(step_vld_i) |-> (!rd_o && !wr_o));
  // R8
  areg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(step_vld_i && areg_ld_i) |-> $stable(areg_q));
endmodule

bind ring_addr_gen ring_addr_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .step_vld_i (step_vld_i),
  .step_idx_i (step_idx_i),
  .rd_req_i   (rd_req_i),
  .wr_req_i   (wr_req_i),
  .areg_ld_i  (areg_ld_i),
  .addr_o     (addr_o),
  .rd_o       (rd_o),
  .wr_o       (wr_o),
  .areg_q     (areg_q)
);

// File: tb/ring_addr_gen_bench.sv
`timescale 1ns/1ps
module ring_addr_gen_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        base_we = 0, cfg_we = 0, vld = 0, tbl = 0, rd = 0, wr = 0;
  logic        add_ar = 0, add_one = 0, ar_ld = 0;
  logic [4:0]  base_idx = 0, sel = 0;
  logic [15:0] base_data = 0, ofs = 0;
  logic [16:0] rlen = 0;
  logic [6:0]  rbase = 0, step = 0;
  logic [1:0]  smode = 0;
  logic [23:0] sval = 0, ival = 0;
  logic [18:0] addr_o;
  logic        rd_o, wr_o;

  int checks = 0, errors = 0;
  int m_base [32];
  int m_ar = 0, m_len = 'h8000, m_rb = 0;
  int e_addr = 0;
  bit e_rd = 0, e_wr = 0;

  always #2 clk = ~clk;

  ring_addr_gen u_ring_addr_gen (
    .clk_i(clk), .rst_ni,
    .base_we_i(base_we), .base_idx_i(base_idx), .base_data_i(base_data),
    .cfg_we_i(cfg_we), .ring_len_i(rlen), .ring_base_i(rbase),
    .step_vld_i(vld), .step_idx_i(step), .ring_ofs_i(ofs), .tbl_mode_i(tbl),
    .rd_req_i(rd), .wr_req_i(wr), .base_sel_i(sel), .add_areg_i(add_ar),
    .add_one_i(add_one), .areg_ld_i(ar_ld), .shift_mode_i(smode),
    .shift_val_i(sval), .in_val_i(ival), .addr_o, .rd_o, .wr_o
  );

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int model_addr();
    int s, a;
    s = m_base[sel];
    if (!tbl)    s += ofs;
    if (add_ar)  s += m_ar;
    if (add_one) s += 1;
    s &= 'hFFFF;
    if (!tbl) s &= (m_len - 1);
    a = s + (m_rb * 4096);
    return (a > 'h7FFFF) ? 0 : a;
  endfunction

  task automatic tick(string tag);
    int v;
    if (vld && (rd || wr)) e_addr = model_addr();
    e_rd = vld && rd && step[0];
    e_wr = vld && wr && step[0];
    @(posedge clk);
    if (base_we) m_base[base_idx] = base_data;
    if (cfg_we) begin m_len = rlen; m_rb = rbase; end
    if (vld && ar_ld) begin
      if (smode == 2'd3) m_ar = (sval >> 12) & 'hFFF;
      else begin
        v = ival;
        if (v & 'h800000) v -= 'h1000000;
        m_ar = (v >>> 16) & 'hFFF;
      end
    end
    @(negedge clk);
    chk(tag, addr_o, e_addr, "addr_o");
    chk(tag, rd_o, e_rd, "rd_o");
    chk(tag, wr_o, e_wr, "wr_o");
  endtask

  task automatic clr();
    base_we = 0; cfg_we = 0; vld = 0; tbl = 0; rd = 0; wr = 0;
    add_ar = 0; add_one = 0; ar_ld = 0; smode = 0;
  endtask

  task automatic wbase(int i, int d);
    clr(); base_we = 1; base_idx = 5'(i); base_data = 16'(d);
    tick("R10"); clr();
  endtask

  task automatic go(string tag, int s, bit t, bit r, bit w, int b, int o);
    clr(); vld = 1; step = 7'(s); tbl = t; rd = r; wr = w; sel = 5'(b); ofs = 16'(o);
  endtask

  initial begin
    #300000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    foreach (m_base[i]) m_base[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state, default ring length and zero bases
    chk("R1", addr_o, 0, "addr_o"); chk("R1", rd_o, 0, "rd_o"); chk("R1", wr_o, 0, "wr_o");
    go("R1", 1, 0, 1, 0, 9, 'h9000); tick("R1");      // (0x9000)&0x7FFF = 0x1000
    chk("R1", addr_o, 'h1000, "default len");
    // R2 ring mode and fold
    wbase(3, 'h1234);
    go("R2", 1, 0, 1, 0, 3, 'h0100); tick("R2");
    chk("R2", addr_o, 'h1334, "ring sum");
    wbase(4, 'h7F00);
    go("R2", 3, 0, 0, 1, 4, 'h0200); tick("R2");
    chk("R2", addr_o, 'h0100, "ring wrap");
    // R3 table mode
    wbase(5, 'hF000);
    go("R3", 5, 1, 1, 0, 5, 'h5000); tick("R3");
    chk("R3", addr_o, 'hF000, "table");
    // R10 config, R4 add-one
    clr(); cfg_we = 1; rlen = 17'h1000; rbase = 7'd5; tick("R10"); clr();
    wbase(6, 'h0ABC);
    go("R4", 7, 0, 1, 0, 6, 'h0F00); add_one = 1; tick("R4");
    chk("R4", addr_o, 'h59BD, "add one");
    // R8 load from input byte, R7 no request holds address
    go("R7", 9, 0, 0, 0, 6, 0); ar_ld = 1; ival = 24'h7F1234; tick("R7");
    chk("R7", addr_o, 'h59BD, "hold");
    go("R4", 9, 0, 1, 0, 6, 0); add_ar = 1; tick("R4");
    chk("R4", addr_o, 'h5B3B, "add areg 0x07F");
    go("R8", 11, 0, 0, 0, 0, 0); ar_ld = 1; ival = 24'h80FFFF; tick("R8");
    go("R8", 11, 1, 1, 0, 0, 0); add_ar = 1; tick("R8");
    chk("R8", addr_o, 'h5F80, "neg byte");
    // R8 same-step ordering, shift mode 3
    go("R8", 13, 1, 1, 0, 0, 0); add_ar = 1; ar_ld = 1; smode = 3; sval = 24'hABC123; tick("R8");
    chk("R8", addr_o, 'h5F80, "old value used");
    go("R8", 13, 1, 1, 0, 0, 0); add_ar = 1; tick("R8");
    chk("R8", addr_o, 'h5ABC, "mode 3");
    // R6 even step
    go("R6", 2, 1, 1, 1, 3, 0); tick("R6");
    chk("R6", rd_o, 0, "even rd"); chk("R6", addr_o, 'h6234, "even addr");
    // R5 clamp
    clr(); cfg_we = 1; rlen = 17'h10000; rbase = 7'h7F; tick("R10");
    wbase(7, 'hFFFF);
    go("R5", 1, 1, 1, 0, 7, 0); tick("R5");
    chk("R5", addr_o, 0, "clamp");
    go("R5", 1, 1, 1, 0, 0, 0); tick("R5");
    chk("R5", addr_o, 'h7F000, "top in range");
    // R9 invalid step ignored
    go("R9", 1, 1, 1, 1, 7, 0); vld = 0; ar_ld = 1; smode = 3; sval = 24'h555000; tick("R9");
    go("R9", 1, 1, 1, 0, 0, 0); add_ar = 1; smode = 0; tick("R9");
    chk("R9", addr_o, 'h7FABC, "areg kept");
    // random, compared each clock
    for (int n = 0; n < 400; n++) begin
      clr();
      if (n % 37 == 0) begin
        cfg_we = 1; rlen = 17'(1 << ($urandom % 17)); rbase = 7'($urandom);
      end
      if (n % 5 == 0) begin
        base_we = 1; base_idx = 5'($urandom); base_data = 16'($urandom);
      end
      vld = ($urandom % 4) != 0; step = 7'($urandom); tbl = 1'($urandom);
      rd = 1'($urandom); wr = 1'($urandom); sel = 5'($urandom); ofs = 16'($urandom);
      add_ar = 1'($urandom); add_one = 1'($urandom); ar_ld = 1'($urandom);
      smode = 2'($urandom); sval = 24'($urandom); ival = 24'($urandom);
      tick("R2");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule